// File: doc/BRIEF.md
# Paged Memory Chip-Select Decoder

This block watches the bus cycles of an 8-bit microcontroller that drives a 20-bit address. The top four address bits split the address space into sixteen 64K pages. From the page, and for flash also from the full address, the block picks one external target: flash, SRAM, a serial-EEPROM window or the peripheral register space. It then drives that target's active-low select for the next clock cycle. Page 0 belongs to the controller's on-chip memories, so an access there drives no select.

Two pages can be steered by software. Page 2 normally reaches the EEPROM window and can be moved to flash. Page 4 normally reaches flash and can be moved to SRAM. The steering bits sit in a small register at offset 0 of the peripheral page. The controller writes it over the same bus and can read it back. The flash device must not be selected below a fixed floor address. Any flash-bound access under that floor drives no select at all. The memories use the read and write strobes directly as output enable and read/write select, so the block only samples those strobes to decode accesses to the steering register.

Top module: `mcu_page_decoder`

## Requirements
- R1: While reset is held and on the first cycle after it, all four selects are high, both steering bits are 0 (page 2 to EEPROM, page 4 to flash) and the readback is 8'h00.
- R2: Selects are registered. The bus state sampled at a clock edge appears on the selects after that edge. With the address strobe high at that edge, all selects are high.
- R3: An access to page 0 (address bits 19:16 = 0) drives no select.
- R4: Page 1 drives only the peripheral select, and page 3 drives only the SRAM select.
- R5: Page 2 drives the EEPROM select when steering bit 0 is 0. When the bit is 1 the page is bound to flash, but it lies under the flash floor, so it drives no select.
- R6: Page 4 drives the flash select when steering bit 1 is 0, and the SRAM select when it is 1.
- R7: Pages 5 through 15 drive the flash select.
- R8: The flash select never goes low for an address below 0x40000.
- R9: At most one select is low in any cycle.
- R10: An access with the strobe low, write strobe low and address 0x10000 loads data bits 1:0 into steering bits 0 and 1. The new value is in effect from the next cycle.
- R11: A write to any other address, or a write while the strobe is high, leaves the steering bits unchanged.
- R12: An access with the strobe low, read strobe low and address 0x10000 returns {6'b0, bit1, bit0} on the readback in the next cycle. Every other cycle the readback is 8'h00.
- R13: Asserting the synchronous reset after the steering bits were set returns them to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_addr | input | 20 | Controller address bus |
| bus_wdata | input | 8 | Controller data bus, as seen by the block |
| bus_as_n | input | 1 | Address strobe, active low |
| bus_rd_n | input | 1 | Read strobe, active low |
| bus_wr_n | input | 1 | Write strobe, active low |
| flash_cs_n | output | 1 | Flash select, active low |
| sram_cs_n | output | 1 | SRAM select, active low |
| eeprom_cs_n | output | 1 | Serial-EEPROM window select, active low |
| periph_cs_n | output | 1 | Peripheral register space select, active low |
| remap_rdata | output | 8 | Steering register readback |

## Verification
The assertions check properties that must hold on every cycle after reset:
- at most one select is low;
- an idle strobe releases every select on the next cycle;
- page 0 stays unselected;
- pages 5 to 15 reach flash;
- flash is never selected under the floor;
- the steering bits hold when there is no matching write;
- the readback is zero when there is no matching read.

Only the bench scenarios can show the page-to-target mapping under each of the four steering settings, that a write takes effect on the very next access, that writes to nearby addresses are ignored, and that reset restores the defaults after software changed them.

// File: rtl/mpd_pkg.sv
// Package: shared types for the paged chip-select decoder.
// Assumes: four external targets at most, one select each.
package mpd_pkg;

    // Decoded destination of one bus access
    typedef enum logic [2:0] {
        TGT_NONE   = 3'd0,
        TGT_PERIPH = 3'd1,
        TGT_SRAM   = 3'd2,
        TGT_EEPROM = 3'd3,
        TGT_FLASH  = 3'd4
    } tgt_e;

    // Active-low select bundle, one bit per target
    typedef struct packed {
        logic flash_n;
        logic sram_n;
        logic eeprom_n;
        logic periph_n;
    } cs_vec_t;

    localparam cs_vec_t CS_IDLE = '{flash_n: 1'b1, sram_n: 1'b1, eeprom_n: 1'b1, periph_n: 1'b1};

endpackage

// File: rtl/mpd_page_lookup.sv
// Module: mpd_page_lookup
// Maps an address and the two steering bits to one target.
// Assumes: page 0 is on-chip; unnamed pages above page 0 belong to flash;
// flash-bound addresses under FLASH_FLOOR are dropped to no target.
module mpd_page_lookup
    import mpd_pkg::*;
#(
    parameter int ADDR_W      = 20,
    parameter int PAGE_W      = 4,
    parameter int PERIPH_PAGE = 1,
    parameter int SWAP_A_PAGE = 2,
    parameter int SRAM_PAGE   = 3,
    parameter int SWAP_B_PAGE = 4,
    parameter logic [ADDR_W-1:0] FLASH_FLOOR = 20'h40000
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              swap_a,
    input  logic              swap_b,
    output tgt_e              tgt
);

    localparam int PAGE_LSB = ADDR_W - PAGE_W;

    logic [PAGE_W-1:0] page;
    tgt_e              raw_tgt;

    assign page = addr[ADDR_W-1:PAGE_LSB];

    // Choose the target from the page number and steering bits
    always_comb begin
        if (page == '0)
            raw_tgt = TGT_NONE;
        else if (page == PAGE_W'(PERIPH_PAGE))
            raw_tgt = TGT_PERIPH;
        else if (page == PAGE_W'(SRAM_PAGE))
            raw_tgt = TGT_SRAM;
        else if (page == PAGE_W'(SWAP_A_PAGE))
            raw_tgt = swap_a ? TGT_FLASH : TGT_EEPROM;
        else if (page == PAGE_W'(SWAP_B_PAGE))
            raw_tgt = swap_b ? TGT_SRAM : TGT_FLASH;
        else
            raw_tgt = TGT_FLASH;
    end

    // Drop flash accesses that fall under the usable floor
    always_comb begin
        if (raw_tgt == TGT_FLASH && addr < FLASH_FLOOR)
            tgt = TGT_NONE;
        else
            tgt = raw_tgt;
    end

endmodule

// File: rtl/mpd_remap_reg.sv
// Module: mpd_remap_reg
// Holds the two steering bits and returns them on a registered readback.
// Assumes: write and read hits are already decoded by the caller.
module mpd_remap_reg #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_hit,
    input  logic              rd_hit,
    input  logic [DATA_W-1:0] wdata,
    output logic              swap_a,
    output logic              swap_b,
    output logic [DATA_W-1:0] rdata
);

    // Load the steering bits on a matching write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            swap_a <= 1'b0;
            swap_b <= 1'b0;
        end else if (wr_hit) begin
            swap_a <= wdata[0];
            swap_b <= wdata[1];
        end
    end

    // Register the readback, zero unless a matching read is seen
    always_ff @(posedge clk) begin
        if (!rst_n)
            rdata <= '0;
        else if (rd_hit)
            rdata <= {{(DATA_W-2){1'b0}}, swap_b, swap_a};
        else
            rdata <= '0;
    end

    a_r11_hold_without_write: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_hit |=> ($stable(swap_a) && $stable(swap_b)));

    a_r12_zero_without_read: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_hit |=> (rdata == '0));

endmodule

// File: rtl/mpd_cs_outreg.sv
// Module: mpd_cs_outreg
// Turns a decoded target into registered active-low selects.
// Assumes: the strobe input is already synchronous to clk.
module mpd_cs_outreg
    import mpd_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    as_n,
    input  tgt_e    tgt,
    output cs_vec_t cs
);

    cs_vec_t cs_next;

    // One-cold select vector for the target, idle when the strobe is high
    always_comb begin
        cs_next = CS_IDLE;
        if (!as_n) begin
            case (tgt)
                TGT_PERIPH: cs_next.periph_n = 1'b0;
                TGT_SRAM:   cs_next.sram_n   = 1'b0;
                TGT_EEPROM: cs_next.eeprom_n = 1'b0;
                TGT_FLASH:  cs_next.flash_n  = 1'b0;
                default:    cs_next          = CS_IDLE;
            endcase
        end
    end

    // Register the selects
    always_ff @(posedge clk) begin
        if (!rst_n)
            cs <= CS_IDLE;
        else
            cs <= cs_next;
    end

    a_r9_single_select: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(~cs) <= 1);

    a_r2_idle_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        as_n |=> (cs == CS_IDLE));

endmodule

// File: rtl/mcu_page_decoder.sv
// Module: mcu_page_decoder (top)
// Decodes controller bus cycles into registered chip selects and holds the
// page steering register at offset REMAP_OFFSET of the peripheral page.
// Assumes: bus inputs are synchronous to clk; strobes are active low.
module mcu_page_decoder
    import mpd_pkg::*;
#(
    parameter int ADDR_W       = 20,
    parameter int DATA_W       = 8,
    parameter int PAGE_W       = 4,
    parameter int PERIPH_PAGE  = 1,
    parameter int SWAP_A_PAGE  = 2,
    parameter int SRAM_PAGE    = 3,
    parameter int SWAP_B_PAGE  = 4,
    parameter int REMAP_OFFSET = 0,
    parameter logic [ADDR_W-1:0] FLASH_FLOOR = 20'h40000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_as_n,
    input  logic              bus_rd_n,
    input  logic              bus_wr_n,
    output logic              flash_cs_n,
    output logic              sram_cs_n,
    output logic              eeprom_cs_n,
    output logic              periph_cs_n,
    output logic [DATA_W-1:0] remap_rdata
);

    localparam int OFFS_W = ADDR_W - PAGE_W;

    logic [PAGE_W-1:0] page;
    logic [OFFS_W-1:0] offs;
    logic              reg_hit;
    logic              wr_hit;
    logic              rd_hit;
    logic              swap_a;
    logic              swap_b;
    tgt_e              tgt;
    cs_vec_t           cs;

    assign page = bus_addr[ADDR_W-1:OFFS_W];
    assign offs = bus_addr[OFFS_W-1:0];

    // Decode accesses to the steering register
    always_comb begin
        reg_hit = !bus_as_n && (page == PAGE_W'(PERIPH_PAGE))
                  && (offs == OFFS_W'(REMAP_OFFSET));
        wr_hit  = reg_hit && !bus_wr_n;
        rd_hit  = reg_hit && !bus_rd_n;
    end

    mpd_remap_reg #(
        .DATA_W (DATA_W)
    ) remap_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_hit (wr_hit),
        .rd_hit (rd_hit),
        .wdata  (bus_wdata),
        .swap_a (swap_a),
        .swap_b (swap_b),
        .rdata  (remap_rdata)
    );

    mpd_page_lookup #(
        .ADDR_W      (ADDR_W),
        .PAGE_W      (PAGE_W),
        .PERIPH_PAGE (PERIPH_PAGE),
        .SWAP_A_PAGE (SWAP_A_PAGE),
        .SRAM_PAGE   (SRAM_PAGE),
        .SWAP_B_PAGE (SWAP_B_PAGE),
        .FLASH_FLOOR (FLASH_FLOOR)
    ) lookup_i (
        .addr   (bus_addr),
        .swap_a (swap_a),
        .swap_b (swap_b),
        .tgt    (tgt)
    );

    mpd_cs_outreg outreg_i (
        .clk   (clk),
        .rst_n (rst_n),
        .as_n  (bus_as_n),
        .tgt   (tgt),
        .cs    (cs)
    );

    // Break the select bundle out to ports
    always_comb begin
        flash_cs_n  = cs.flash_n;
        sram_cs_n   = cs.sram_n;
        eeprom_cs_n = cs.eeprom_n;
        periph_cs_n = cs.periph_n;
    end

    a_r3_page0_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_as_n && page == '0) |=>
        (flash_cs_n && sram_cs_n && eeprom_cs_n && periph_cs_n));

    a_r7_high_pages_flash: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_as_n && page > PAGE_W'(SWAP_B_PAGE)) |=> !flash_cs_n);

    a_r8_flash_floor: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr < FLASH_FLOOR) |=> flash_cs_n);

endmodule

// File: tb/mcu_page_decoder_tb_top.sv
// Bench: sweeps every page under all four steering settings and checks
// selects and readback against values computed from the requirements.
module mcu_page_decoder_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [19:0] bus_addr = '0;
    logic [7:0]  bus_wdata = '0;
    logic        bus_as_n = 1'b1;
    logic        bus_rd_n = 1'b1;
    logic        bus_wr_n = 1'b1;
    logic        flash_cs_n, sram_cs_n, eeprom_cs_n, periph_cs_n;
    logic [7:0]  remap_rdata;

    int total = 0;
    int bad   = 0;

    always #10 clk = ~clk;

    mcu_page_decoder dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .bus_addr    (bus_addr),
        .bus_wdata   (bus_wdata),
        .bus_as_n    (bus_as_n),
        .bus_rd_n    (bus_rd_n),
        .bus_wr_n    (bus_wr_n),
        .flash_cs_n  (flash_cs_n),
        .sram_cs_n   (sram_cs_n),
        .eeprom_cs_n (eeprom_cs_n),
        .periph_cs_n (periph_cs_n),
        .remap_rdata (remap_rdata)
    );

    // Expected {flash,sram,eeprom,periph}, active low
    function automatic logic [3:0] exp_cs(input logic [19:0] a, input logic [1:0] sw,
                                          input logic as_n);
        logic [3:0] pg;
        logic [3:0] r;
        pg = a[19:16];
        r  = 4'b1111;
        if (!as_n) begin
            if (pg == 4'd1)      r = 4'b1110;
            else if (pg == 4'd3) r = 4'b1011;
            else if (pg == 4'd2) r = sw[0] ? 4'b1111 : 4'b1101;
            else if (pg == 4'd4) r = sw[1] ? 4'b1011 : 4'b0111;
            else if (pg != 4'd0) r = 4'b0111;
        end
        return r;
    endfunction

    task automatic check_cs(input string req, input logic [3:0] exp);
        logic [3:0] act;
        act = {flash_cs_n, sram_cs_n, eeprom_cs_n, periph_cs_n};
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s addr=%05h cs act=%b exp=%b", req, bus_addr, act, exp);
        end
    endtask

    task automatic check_rd(input string req, input logic [7:0] exp);
        total++;
        if (remap_rdata !== exp) begin
            bad++;
            $display("FAIL %s readback act=%02h exp=%02h", req, remap_rdata, exp);
        end
    endtask

    // One bus cycle: drive at negedge, check at the following negedge
    task automatic bus_cycle(input logic [19:0] a, input logic as_n, input logic rd_n,
                             input logic wr_n, input logic [7:0] d);
        @(negedge clk);
        bus_addr  = a;
        bus_as_n  = as_n;
        bus_rd_n  = rd_n;
        bus_wr_n  = wr_n;
        bus_wdata = d;
        @(negedge clk);
    endtask

    task automatic go_idle();
        bus_as_n = 1'b1;
        bus_rd_n = 1'b1;
        bus_wr_n = 1'b1;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [1:0] sw;
        // R1: reset state
        repeat (3) @(negedge clk);
        check_cs("R1", 4'b1111);
        check_rd("R1", 8'h00);
        rst_n = 1'b1;
        @(negedge clk);
        check_cs("R1", 4'b1111);
        // R1: defaults visible on readback
        bus_cycle(20'h10000, 1'b0, 1'b0, 1'b1, 8'h00);
        check_rd("R1", 8'h00);
        check_cs("R4", 4'b1110);
        go_idle();

        for (int s = 0; s < 4; s++) begin
            sw = s[1:0];
            // R10: write steering bits, upper data bits ignored
            bus_cycle(20'h10000, 1'b0, 1'b1, 1'b0, {6'b101010, sw});
            go_idle();
            // R12: readback reflects the written value
            bus_cycle(20'h10000, 1'b0, 1'b0, 1'b1, 8'hFF);
            check_rd("R12", {6'b0, sw});
            go_idle();
            for (int p = 0; p < 16; p++) begin
                for (int o = 0; o < 3; o++) begin
                    for (int st = 0; st < 2; st++) begin
                        logic [19:0] a;
                        a = {p[3:0], (o == 0) ? 16'h0000 : (o == 1) ? 16'h8001 : 16'hFFFF};
                        bus_cycle(a, st[0], 1'b1, 1'b1, 8'h00);
                        // R2 R3 R4 R5 R6 R7 R8 R9
                        if (st == 1)       check_cs("R2", exp_cs(a, sw, 1'b1));
                        else if (p == 0)   check_cs("R3", exp_cs(a, sw, 1'b0));
                        else if (p == 2)   check_cs("R5", exp_cs(a, sw, 1'b0));
                        else if (p == 4)   check_cs("R6", exp_cs(a, sw, 1'b0));
                        else if (p >= 5)   check_cs("R7", exp_cs(a, sw, 1'b0));
                        else               check_cs("R4", exp_cs(a, sw, 1'b0));
                        check_rd("R12", 8'h00);
                    end
                end
            end
        end

        // R11: write to a neighbouring offset is ignored (steering is 3 now)
        bus_cycle(20'h10001, 1'b0, 1'b1, 1'b0, 8'h00);
        bus_cycle(20'h20000, 1'b0, 1'b1, 1'b1, 8'h00);
        check_cs("R11", 4'b1111);
        // R11: write with strobe high is ignored
        bus_cycle(20'h10000, 1'b1, 1'b1, 1'b0, 8'h00);
        bus_cycle(20'h10000, 1'b0, 1'b0, 1'b1, 8'h00);
        check_rd("R11", 8'h03);
        // R12: read at another offset returns zero
        bus_cycle(20'h10002, 1'b0, 1'b0, 1'b1, 8'h00);
        check_rd("R12", 8'h00);
        // R8: page 2 steered to flash stays unselected at its top address
        bus_cycle(20'h3FFFF, 1'b0, 1'b1, 1'b1, 8'h00);
        check_cs("R8", 4'b1011);
        bus_cycle(20'h2FFFF, 1'b0, 1'b1, 1'b1, 8'h00);
        check_cs("R8", 4'b1111);
        go_idle();

        // R13: synchronous reset restores defaults
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        bus_cycle(20'h20000, 1'b0, 1'b1, 1'b1, 8'h00);
        check_cs("R13", 4'b1101);
        bus_cycle(20'h40000, 1'b0, 1'b1, 1'b1, 8'h00);
        check_cs("R13", 4'b0111);
        bus_cycle(20'h10000, 1'b0, 1'b0, 1'b1, 8'h00);
        check_rd("R13", 8'h00);
        go_idle();
        @(negedge clk);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule